// File: doc/BRIEF.md
# Bus hold request controller

This block decides who owns a processor's external memory bus. An outside master asks for the bus by pulling an active-low hold request low. The controller lets any bus cycle already in flight finish. It then hands the bus over by pulling an active-low hold acknowledge low, releasing the address, data and strobe drivers and stalling the core. While the bus is handed over and the core has a cycle waiting, an active-low bus request output asks the outside master to give the bus back.

Software gates the protocol through a hold-enable bit, which can be written at any time. Clearing the bit in the middle of a hold does not take the bus back early. The hold in progress runs until the outside master lets go, and only later requests are refused. The first time the bit is set, a pin-function lock flag rises, and it stays set until reset. A status output mirrors the live acknowledge level, so software can poll it to know when a hold has been serviced.

Top module: `bus_hold_ctrl`

## Requirements
- R1: After reset, hold_ack_n and bus_req_n are 1, bus_release and core_stall are 0, and hold_en_q and pin_lock are 0.
- R2: When hold_en_q is 1 and no cycle is active, hold_ack_n goes low at the third rising edge after hold_req_n falls (two synchronizer flops plus the state register).
- R3: hold_ack_n never falls while a core cycle is in progress. It falls at the rising edge where cyc_active and cyc_done are sampled high together, or later.
- R4: While the bus is held, bus_req_n goes low at the edge after a clock in which cyc_pending is 1, and it stays 1 at all other times.
- R5: While hold_ack_n is 0, core_stall and bus_release are both 1.
- R6: When hold_req_n rises, hold_ack_n and bus_req_n return to 1 at the third rising edge. bus_release stays 1 for one further clock and then drops to 0.
- R7: While hold_en_q is 0, hold_req_n never produces a grant.
- R8: Clearing hold_en_q during a hold does not end it. After the hold ends, new requests are ignored until the bit is written to 1 again; a request still waiting is then granted on the second edge after the write.
- R9: pin_lock becomes 1 at the edge where en_we is high with en_wdata 1. It stays 1 when the enable is cleared, and only reset clears it.
- R10: When a request is synchronized and enabled but not yet granted, core_stall is 1 while the bus is still owned, so the core starts no new cycle.
- R11: hold_ack_sts always equals hold_ack_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_req_n | input | 1 | Active-low hold request from the outside master (asynchronous) |
| en_we | input | 1 | Write strobe for the hold-enable bit |
| en_wdata | input | 1 | Value written to the hold-enable bit |
| cyc_pending | input | 1 | Core has an external bus cycle waiting |
| cyc_active | input | 1 | Core bus cycle in progress |
| cyc_done | input | 1 | Current core bus cycle ends this clock |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| bus_req_n | output | 1 | Active-low request to get the bus back |
| bus_release | output | 1 | Tri-states the address, data and strobe drivers |
| core_stall | output | 1 | Keeps the core from starting a bus cycle |
| hold_en_q | output | 1 | Current hold-enable bit |
| pin_lock | output | 1 | Pins locked to their special function until reset |
| hold_ack_sts | output | 1 | Readback of the live acknowledge level |

## Verification
Some rules are checked on every cycle by assertions:
- a grant only at a cycle boundary;
- no grant while disabled;
- stall and release whenever the acknowledge is low;
- bus request only while held;
- the release gap after a hold;
- the lock following the enable.

Other behaviour only the directed scenarios can show:
- the exact latency through the synchronizer;
- the deferred disable over a whole hold and the refusal that follows it;
- the late grant after re-enabling;
- the lock surviving a cleared enable and being cleared by reset.

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_n,
  input  logic en_we,
  input  logic en_wdata,
  input  logic cyc_pending,
  input  logic cyc_active,
  input  logic cyc_done,
  output logic hold_ack_n,
  output logic bus_req_n,
  output logic bus_release,
  output logic core_stall,
  output logic hold_en_q,
  output logic pin_lock,
  output logic hold_ack_sts
);

  typedef enum logic [1:0] {ST_OWN, ST_HELD, ST_GAP} st_t;

  st_t st_q, st_nx;
  logic [SYNC_STAGES-1:0] sync_q;
  logic hold_act, grant, breq_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], hold_req_n};

  assign hold_act = !sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_en_q <= 1'b0;
      pin_lock  <= 1'b0;
    end else if (en_we) begin
      hold_en_q <= en_wdata;
      if (en_wdata) pin_lock <= 1'b1;
    end

  assign grant = (st_q == ST_OWN) && hold_act && hold_en_q && (!cyc_active || cyc_done);

  always_comb begin
    st_nx = st_q;
    case (st_q)
      ST_OWN:  if (grant) st_nx = ST_HELD;
      ST_HELD: if (!hold_act) st_nx = ST_GAP;
      default: st_nx = ST_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q   <= ST_OWN;
      breq_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      breq_q <= (st_q == ST_HELD) && (st_nx == ST_HELD) && cyc_pending;
    end

  assign hold_ack_n   = (st_q != ST_HELD);
  assign bus_req_n    = !breq_q;
  assign bus_release  = (st_q != ST_OWN);
  assign core_stall   = (st_q != ST_OWN) || (hold_act && hold_en_q);
  assign hold_ack_sts = hold_ack_n;

  AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> $past(!cyc_active || cyc_done)); // R3
  AST_NO_GRANT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> $past(hold_en_q)); // R7
  AST_HELD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> (core_stall && bus_release)); // R5
  AST_BREQ_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req_n |-> !hold_ack_n); // R4
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack_n) |-> (bus_release && bus_req_n)); // R6
  AST_LOCK_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_en_q |-> pin_lock); // R9
  AST_STS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack_sts == hold_ack_n); // R11

endmodule

// File: tb/bus_hold_ctrl_tb.sv
module bus_hold_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic hold_req_n = 1, en_we = 0, en_wdata = 0;
  logic cyc_pending = 0, cyc_active = 0, cyc_done = 0;
  logic hold_ack_n, bus_req_n, bus_release, core_stall, hold_en_q, pin_lock, hold_ack_sts;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_ctrl dut_i (.*);

  task automatic chk(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic write_en(logic v);
    en_we = 1; en_wdata = v;
    tick(1);
    en_we = 0;
  endtask

  task automatic release_hold();
    hold_req_n = 1;
    tick(2);
    chk("R6", hold_ack_n, 1'b0, "ack before sync");
    tick(1);
    chk("R6", hold_ack_n, 1'b1, "ack after release");
    chk("R6", bus_req_n, 1'b1, "breq after release");
    chk("R6", bus_release, 1'b1, "release gap");
    tick(1);
    chk("R6", bus_release, 1'b0, "bus back");
    chk("R6", core_stall, 1'b0, "stall cleared");
  endtask

  task automatic t_reset();
    chk("R1", hold_ack_n, 1'b1, "ack");
    chk("R1", bus_req_n, 1'b1, "breq");
    chk("R1", bus_release, 1'b0, "release");
    chk("R1", core_stall, 1'b0, "stall");
    chk("R1", hold_en_q, 1'b0, "en");
    chk("R1", pin_lock, 1'b0, "lock");
  endtask

  task automatic t_grant_idle();
    write_en(1);
    chk("R9", pin_lock, 1'b1, "lock set");
    hold_req_n = 0;
    tick(2);
    chk("R2", hold_ack_n, 1'b1, "ack early");
    chk("R10", core_stall, 1'b1, "stall pending");
    tick(1);
    chk("R2", hold_ack_n, 1'b0, "ack granted");
    chk("R5", core_stall, 1'b1, "stall held");
    chk("R5", bus_release, 1'b1, "release held");
    chk("R11", hold_ack_sts, 1'b0, "status");
    chk("R4", bus_req_n, 1'b1, "breq idle");
    cyc_pending = 1;
    tick(1);
    chk("R4", bus_req_n, 1'b0, "breq asserted");
    release_hold();
    cyc_pending = 0;
  endtask

  task automatic t_grant_cycle();
    cyc_active = 1;
    hold_req_n = 0;
    tick(6);
    chk("R3", hold_ack_n, 1'b1, "no grant mid-cycle");
    chk("R10", core_stall, 1'b1, "stall waiting");
    cyc_done = 1;
    tick(1);
    cyc_done = 0; cyc_active = 0;
    chk("R3", hold_ack_n, 1'b0, "grant at boundary");
    release_hold();
  endtask

  task automatic t_disabled();
    write_en(0);
    hold_req_n = 0;
    tick(6);
    chk("R7", hold_ack_n, 1'b1, "no grant disabled");
    chk("R7", core_stall, 1'b0, "no stall disabled");
    chk("R9", pin_lock, 1'b1, "lock kept");
    hold_req_n = 1;
    tick(3);
  endtask

  task automatic t_deferred();
    write_en(1);
    hold_req_n = 0;
    tick(3);
    chk("R2", hold_ack_n, 1'b0, "granted");
    write_en(0);
    tick(4);
    chk("R8", hold_ack_n, 1'b0, "hold kept after clear");
    release_hold();
    hold_req_n = 0;
    tick(6);
    chk("R8", hold_ack_n, 1'b1, "new request ignored");
    en_we = 1; en_wdata = 1;
    tick(1);
    en_we = 0;
    chk("R8", hold_ack_n, 1'b1, "not yet");
    tick(1);
    chk("R8", hold_ack_n, 1'b0, "granted after re-enable");
    release_hold();
  endtask

  task automatic t_reset_lock();
    rst_n = 0;
    tick(1);
    rst_n = 1;
    tick(1);
    chk("R9", pin_lock, 1'b0, "lock cleared by reset");
    chk("R1", hold_en_q, 1'b0, "en cleared by reset");
  endtask

  initial begin
    tick(2);
    rst_n = 1;
    tick(1);
    t_reset();
    t_grant_idle();
    t_grant_cycle();
    t_disabled();
    t_deferred();
    t_reset_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule